// File: doc/BRIEF.md
# Unlock-Gated Serial Configuration Receiver

This block takes configuration words from a two-wire serial link (one clock line, one data line) and turns them into single-cycle register write strobes. Both lines are brought into the fast system clock domain through synchronizer stages, and all protocol decisions are made on the edges seen there. A transfer is accepted only after an unlock preamble. The preamble is a run of serial clock rising edges with data high, closed by one rising edge with data low.

After unlocking, the receiver expects a start bit and then 24 payload bits. The payload is 21 data bits followed by 3 address bits, both least significant bit first. Each bit is sent as two levels. The data level at the serial clock falling edge must be the inverse of the bit, and the level at the next rising edge is the bit itself. A load command then follows: data held high across both the falling and the rising edge. On that command the 21 data bits go out with a one-hot strobe to one of six registers. Protocol faults pull an active-low error flag low. A watchdog drops any partial preamble or frame when both lines stop moving. A power-down input keeps the receiver locked out.

Top module: `cfg_serial_rx`

## Requirements
- R1: The receiver unlocks only after at least PRE_MIN (default 5) serial clock rising edges with data high, immediately followed by a rising edge with data low. Any low-data rising edge that comes earlier restarts the count.
- R2: After unlocking, every bit must show the inverted level at the serial clock falling edge and the true level at the following rising edge. A bit whose two levels are equal is an error.
- R3: The frame is a start bit of value 0, then data bits d0..d20, then address bits a0..a2, so each field is sent least significant bit first.
- R4: After the 24 payload bits, a rising edge with data high at both that edge and the preceding falling edge is the load command. It produces exactly one single-cycle pulse on `wr_sel_o`, and `wr_data_o` carries d20..d0 in that cycle.
- R5: The address maps to `wr_sel_o` bits as follows: 000→bit0, 001→bit1, 010→bit2, 011→bit3, 100→bit4, 110→bit5. Addresses 101 and 111 produce no strobe.
- R6: A load command given before all 24 payload bits have arrived, or a further encoded bit arriving after them, is a length error. Either one raises the error flag and produces no write.
- R7: A start bit other than a correctly encoded 0, or a final command other than data-high on both edges, is an error and produces no write.
- R8: `err_n_o` is 1 after reset. Any error drives it to 0, and it stays 0 until the next completed unlock preamble.
- R9: When neither line changes for WDOG_CYC system clock cycles, any partial preamble count and any partial frame are discarded and the receiver returns to idle, without raising an error.
- R10: While `pwr_down_i` is high the receiver stays idle: no unlock, no write, and no change to `err_n_o`.
- R11: After a load or an error the receiver is idle again, so the next frame needs a new unlock preamble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock line, asynchronous |
| ser_dat_i | input | 1 | Serial data line, asynchronous |
| pwr_down_i | input | 1 | High while the device is powered down; blocks programming |
| wr_sel_o | output | 6 | One-hot register write strobe, one cycle per load |
| wr_data_o | output | 21 | Data word for the strobed register |
| err_n_o | output | 1 | Sticky active-low protocol error flag |

## Verification
The hardest states to reach are a watchdog expiry partway through a frame, and a preamble split across two bursts by a quiet gap. Both are only visible through the lack of a later event. The bench therefore picks the trailing bits of the interrupted frame so that they cannot form an unlock sequence, and then checks that no strobe appears. For the split preamble it first sets the error flag with a bad frame. A preamble that was wrongly counted as complete would then clear the flag, which is visible at the port. The address decode is swept over all eight codes with several data patterns and preamble lengths.

// File: rtl/cfg_rx_pkg.sv
`timescale 1ns/1ps
// Shared sizes, receiver states and address decode for the serial
// configuration receiver.
package cfg_rx_pkg;
    localparam int DATA_W   = 21;
    localparam int ADDR_W   = 3;
    localparam int FRAME_W  = DATA_W + ADDR_W;
    localparam int NUM_REGS = 6;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_BITS  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;

    // Map a received address to a one-hot register strobe; unused codes give none.
    function automatic logic [NUM_REGS-1:0] addr_to_sel(input logic [ADDR_W-1:0] addr);
        logic [NUM_REGS-1:0] sel;
        case (addr)
            3'd0:    sel = 6'b000001;
            3'd1:    sel = 6'b000010;
            3'd2:    sel = 6'b000100;
            3'd3:    sel = 6'b001000;
            3'd4:    sel = 6'b010000;
            3'd6:    sel = 6'b100000;
            default: sel = '0;
        endcase
        return sel;
    endfunction
endpackage

// File: rtl/cfg_line_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for a group of asynchronous input lines.
// Assumes each line is held stable for longer than STAGES+1 system cycles.
module cfg_line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] lvl_o
);
    logic [LINES-1:0] stg_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // One flop rank of the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stg_q[s] <= '0;
                else if (s == 0)
                    stg_q[s] <= raw_i;
                else
                    stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign lvl_o = stg_q[STAGES-1];
endmodule

// File: rtl/cfg_watchdog.sv
`timescale 1ns/1ps
// Inactivity timer: restarts on every kick and pulses expire_o once
// when LIMIT cycles pass without a kick. Assumes LIMIT >= 2.
module cfg_watchdog #(
    parameter int LIMIT = 100_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_i,
    output logic expire_o
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(LIMIT);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] quiet_q;

    // Count quiet cycles, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || kick_i)
            quiet_q <= '0;
        else if (quiet_q != CNT_MAX)
            quiet_q <= quiet_q + 1'b1;
    end

    assign expire_o = (quiet_q == CNT_LAST) && !kick_i;

    // R9: one expiry per quiet period
    a_r9_single_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> !expire_o);
endmodule

// File: rtl/cfg_preamble_det.sv
`timescale 1ns/1ps
// Unlock detector: counts serial clock rising edges with data high and
// fires on a low-data rising edge once MIN_HIGH of them were seen.
// Counting only runs while en_i is high; clear_i discards the count.
module cfg_preamble_det #(
    parameter int MIN_HIGH = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic clear_i,
    input  logic rise_i,
    input  logic dat_i,
    output logic unlock_o
);
    localparam int CNT_W = $clog2(MIN_HIGH + 1);
    localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_HIGH);

    logic [CNT_W-1:0] hi_cnt_q;

    // Track the run of high-data rising edges, saturating at MIN_HIGH.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i || !en_i)
            hi_cnt_q <= '0;
        else if (rise_i) begin
            if (!dat_i)
                hi_cnt_q <= '0;
            else if (hi_cnt_q != CNT_MIN)
                hi_cnt_q <= hi_cnt_q + 1'b1;
        end
    end

    assign unlock_o = en_i && !clear_i && rise_i && !dat_i && (hi_cnt_q == CNT_MIN);

    // R1: a counted high edge always leaves a nonzero run length
    a_r1_run_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !clear_i && rise_i && dat_i) |=> (hi_cnt_q != '0));
endmodule

// File: rtl/cfg_frame_rx.sv
`timescale 1ns/1ps
// Frame decoder: after start_i checks the start bit, shifts in the
// complement-then-true encoded payload LSB first, and checks the load
// command. Reports load_o or err_o as single-cycle pulses.
// Assumes rise/fall pulses come from one synchronized serial clock.
module cfg_frame_rx
    import cfg_rx_pkg::*;
#(
    parameter int FRAME_W_P = FRAME_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 abort_i,
    input  logic                 rise_i,
    input  logic                 fall_i,
    input  logic                 dat_i,
    output logic                 busy_o,
    output logic                 load_o,
    output logic                 err_o,
    output logic [FRAME_W_P-1:0] word_o
);
    localparam int CNT_W = $clog2(FRAME_W_P);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W_P - 1);

    rx_state_e            st_q;
    logic                 fall_lvl_q;
    logic [CNT_W-1:0]     bit_cnt_q;
    logic [FRAME_W_P-1:0] shift_q;
    logic                 start_ok, bit_ok, stop_ok;

    // Remember the data level seen at the latest falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fall_lvl_q <= 1'b0;
        else if (fall_i)
            fall_lvl_q <= dat_i;
    end

    assign start_ok = fall_lvl_q && !dat_i;
    assign bit_ok   = fall_lvl_q != dat_i;
    assign stop_ok  = fall_lvl_q && dat_i;

    // Sequence through start bit, payload bits and load command.
    always_ff @(posedge clk) begin
        if (!rst_n || abort_i) begin
            st_q      <= RX_IDLE;
            bit_cnt_q <= '0;
        end else begin
            case (st_q)
                RX_IDLE:  if (start_i) st_q <= RX_START;
                RX_START: if (rise_i) begin
                    st_q      <= start_ok ? RX_BITS : RX_IDLE;
                    bit_cnt_q <= '0;
                end
                RX_BITS:  if (rise_i) begin
                    if (!bit_ok)
                        st_q <= RX_IDLE;
                    else if (bit_cnt_q == LAST_BIT)
                        st_q <= RX_STOP;
                    else
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                end
                RX_STOP:  if (rise_i) st_q <= RX_IDLE;
                default:  st_q <= RX_IDLE;
            endcase
        end
    end

    // Shift accepted payload bits in from the top so the first bit lands at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shift_q <= '0;
        else if (st_q == RX_BITS && rise_i && bit_ok && !abort_i)
            shift_q <= {dat_i, shift_q[FRAME_W_P-1:1]};
    end

    assign busy_o = st_q != RX_IDLE;
    assign word_o = shift_q;
    assign load_o = !abort_i && rise_i && st_q == RX_STOP && stop_ok;
    assign err_o  = !abort_i && rise_i &&
                    ((st_q == RX_START && !start_ok) ||
                     (st_q == RX_BITS  && !bit_ok)   ||
                     (st_q == RX_STOP  && !stop_ok));

    // R6: payload counter never passes the frame length
    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RX_BITS) |-> (bit_cnt_q <= LAST_BIT));
    // R2: a bit is either loaded or rejected, never both
    a_r2_load_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_o && err_o));
    // R9: abort always returns to idle
    a_r9_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (st_q == RX_IDLE));
    // R11: after a load the receiver needs a new unlock
    a_r11_load_idle: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> (st_q == RX_IDLE));
endmodule

// File: rtl/cfg_serial_rx.sv
`timescale 1ns/1ps
// Top: synchronizes the two serial lines, finds edges, runs the unlock
// detector, frame decoder and watchdog, and drives the write strobe and
// the sticky error flag. Assumes pwr_down_i is synchronous to clk.
module cfg_serial_rx
    import cfg_rx_pkg::*;
#(
    parameter int WDOG_CYC    = 100_000,
    parameter int PRE_MIN     = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ser_clk_i,
    input  logic                ser_dat_i,
    input  logic                pwr_down_i,
    output logic [NUM_REGS-1:0] wr_sel_o,
    output logic [DATA_W-1:0]   wr_data_o,
    output logic                err_n_o
);
    localparam int CLK_IX = 0;
    localparam int DAT_IX = 1;

    logic [1:0]         lvl, last_q, rise, fall;
    logic               kick, expire, abort, unlock;
    logic               busy, load, frame_err;
    logic [FRAME_W-1:0] word;

    cfg_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .raw_i({ser_dat_i, ser_clk_i}), .lvl_o(lvl)
    );

    // Keep the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= '0;
        else
            last_q <= lvl;
    end

    assign rise  = lvl & ~last_q;
    assign fall  = ~lvl & last_q;
    assign kick  = |(rise | fall);
    assign abort = expire || pwr_down_i;

    cfg_watchdog #(.LIMIT(WDOG_CYC)) u_wdog (
        .clk(clk), .rst_n(rst_n), .kick_i(kick), .expire_o(expire)
    );

    cfg_preamble_det #(.MIN_HIGH(PRE_MIN)) u_pre (
        .clk(clk), .rst_n(rst_n),
        .en_i(!busy && !pwr_down_i), .clear_i(expire),
        .rise_i(rise[CLK_IX]), .dat_i(lvl[DAT_IX]), .unlock_o(unlock)
    );

    cfg_frame_rx u_frame (
        .clk(clk), .rst_n(rst_n),
        .start_i(unlock), .abort_i(abort),
        .rise_i(rise[CLK_IX]), .fall_i(fall[CLK_IX]), .dat_i(lvl[DAT_IX]),
        .busy_o(busy), .load_o(load), .err_o(frame_err), .word_o(word)
    );

    // Issue the one-cycle write strobe and latch the data word on a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_sel_o  <= '0;
            wr_data_o <= '0;
        end else begin
            wr_sel_o <= load ? addr_to_sel(word[FRAME_W-1:DATA_W]) : '0;
            if (load)
                wr_data_o <= word[DATA_W-1:0];
        end
    end

    // Sticky error flag: set by any frame error, cleared by an unlock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_n_o <= 1'b1;
        else if (unlock)
            err_n_o <= 1'b1;
        else if (frame_err)
            err_n_o <= 1'b0;
    end

    // R4: at most one register is strobed per cycle
    a_r4_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel_o));
    // R8: the flag stays low until an unlock
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_n_o && !unlock) |=> !err_n_o);
    // R10: power-down blocks writes
    a_r10_pd_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_down_i && $past(pwr_down_i)) |=> (wr_sel_o == '0));
endmodule

// File: tb/tb_cfg_serial_rx.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps every address with several data patterns
// and preamble lengths, then drives each protocol fault and corner case.
module tb_cfg_serial_rx;
    localparam int WD = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b1;
    logic        ser_dat = 1'b0;
    logic        pd = 1'b0;
    logic [5:0]  wr_sel;
    logic [20:0] wr_data;
    logic        err_n;

    int n_chk = 0;
    int n_err = 0;
    int wr_cnt = 0;
    logic [5:0]  last_sel = '0;
    logic [20:0] last_data = '0;
    bit done = 0;

    cfg_serial_rx #(.WDOG_CYC(WD)) dut (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
        .pwr_down_i(pd), .wr_sel_o(wr_sel), .wr_data_o(wr_data), .err_n_o(err_n)
    );

    always #5 clk = ~clk;   // 100 MHz

    // Record every strobe seen at the ports.
    always @(posedge clk) begin
        if (rst_n && wr_sel != 6'd0) begin
            wr_cnt++;
            last_sel  = wr_sel;
            last_data = wr_data;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R5 address map as stated in the requirement.
    function automatic logic [5:0] exp_sel(input logic [2:0] a);
        case (a)
            3'd0: return 6'b000001;
            3'd1: return 6'b000010;
            3'd2: return 6'b000100;
            3'd3: return 6'b001000;
            3'd4: return 6'b010000;
            3'd6: return 6'b100000;
            default: return 6'b000000;
        endcase
    endfunction

    // One serial clock period: level f at the falling edge, r at the rising edge.
    task automatic phase(input logic f, input logic r);
        @(negedge clk) ser_dat = f;
        repeat (2) @(negedge clk);
        ser_clk = 1'b0;
        repeat (4) @(negedge clk);
        ser_dat = r;
        repeat (2) @(negedge clk);
        ser_clk = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        phase(!b, b);
    endtask

    task automatic preamble(input int n);
        repeat (n) phase(1'b1, 1'b1);
        phase(1'b0, 1'b0);
    endtask

    task automatic send_word(input logic [20:0] d, input logic [2:0] a, input int from, input int to);
        logic [23:0] w;
        w = {a, d};
        for (int i = from; i < to; i++) send_bit(w[i]);
    endtask

    task automatic gap();
        repeat (2 * WD) @(negedge clk);
    endtask

    task automatic settle();
        repeat (10) @(negedge clk);
    endtask

    task automatic xfer(input int npre, input logic [20:0] d, input logic [2:0] a);
        gap();
        preamble(npre);
        send_bit(1'b0);
        send_word(d, a, 0, 24);
        phase(1'b1, 1'b1);
        settle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int base;
        logic [20:0] d;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 reset err_n", err_n, 1);
        check("R4 reset wr_sel", wr_sel, 0);

        // R3 R4 R5: full address sweep with several data patterns
        for (int a = 0; a < 8; a++) begin
            for (int k = 0; k < 3; k++) begin
                d = 21'(a * 21'h0B6D5 + 21'h12345);
                if (k == 0) d = 21'h1FFFFF ^ 21'(a * 21'h1111);
                if (k == 2) d = ~d;
                base = wr_cnt;
                xfer(5 + (a % 4), d, 3'(a));
                check("R5 strobe count", wr_cnt - base, (exp_sel(3'(a)) != 0) ? 1 : 0);
                if (exp_sel(3'(a)) != 0) begin
                    check("R5 strobe select", last_sel, exp_sel(3'(a)));
                    check("R3 R4 data word", last_data, d);
                end
                check("R2 no error on valid frame", err_n, 1);
            end
        end

        // R11: frame without a new preamble is ignored
        base = wr_cnt;
        send_bit(1'b0);
        send_word(21'h0, 3'd0, 0, 24);
        phase(1'b1, 1'b1);
        settle();
        check("R11 no write without unlock", wr_cnt - base, 0);

        // R7: bad start bit
        base = wr_cnt;
        gap(); preamble(5); send_bit(1'b1); settle();
        check("R7 bad start err_n", err_n, 0);
        check("R7 bad start no write", wr_cnt - base, 0);
        gap();
        check("R8 err_n sticky over gap", err_n, 0);

        // R1: four high edges do not unlock (flag stays low)
        preamble(4); settle();
        check("R1 short preamble no unlock", err_n, 0);
        // R9: preamble split by a quiet gap does not unlock
        gap();
        repeat (3) phase(1'b1, 1'b1);
        gap();
        repeat (3) phase(1'b1, 1'b1);
        phase(1'b0, 1'b0); settle();
        check("R9 split preamble no unlock", err_n, 0);
        // R8: a completed unlock clears the flag
        gap(); preamble(5); settle();
        check("R8 unlock clears err_n", err_n, 1);

        // R2: bad encoding in the middle of the payload
        base = wr_cnt;
        gap(); preamble(5); send_bit(1'b0);
        send_word(21'h5, 3'd0, 0, 5);
        phase(1'b0, 1'b0); settle();
        check("R2 bad encoding err_n", err_n, 0);
        check("R2 bad encoding no write", wr_cnt - base, 0);

        // R6: load command one bit early
        gap(); preamble(5); settle();
        base = wr_cnt;
        gap(); preamble(5); send_bit(1'b0);
        send_word(21'h0A5A5, 3'd1, 0, 23);
        phase(1'b1, 1'b1); settle();
        check("R6 early stop err_n", err_n, 0);
        check("R6 early stop no write", wr_cnt - base, 0);

        // R6: an extra bit after the full payload
        gap(); preamble(5); settle();
        base = wr_cnt;
        gap(); preamble(5); send_bit(1'b0);
        send_word(21'h0A5A5, 3'd1, 0, 24);
        send_bit(1'b1); settle();
        check("R6 extra bit err_n", err_n, 0);
        check("R6 extra bit no write", wr_cnt - base, 0);

        // R7: bad final command
        gap(); preamble(5); settle();
        base = wr_cnt;
        gap(); preamble(5); send_bit(1'b0);
        send_word(21'h1234, 3'd2, 0, 24);
        phase(1'b0, 1'b0); settle();
        check("R7 bad stop err_n", err_n, 0);
        check("R7 bad stop no write", wr_cnt - base, 0);
        gap(); preamble(5); settle();
        check("R8 unlock clears err_n again", err_n, 1);

        // R9: watchdog expiry part way through a frame
        base = wr_cnt;
        gap(); preamble(5); send_bit(1'b0);
        send_word(21'h15, 3'd3, 0, 10);
        gap();
        send_word(21'h15, 3'd3, 10, 24);
        phase(1'b1, 1'b1); settle();
        check("R9 stalled frame no write", wr_cnt - base, 0);
        check("R9 stall raises no error", err_n, 1);
        base = wr_cnt;
        xfer(5, 21'h0F0F0, 3'd4);
        check("R9 recovery write", wr_cnt - base, 1);
        check("R9 recovery data", last_data, 21'h0F0F0);

        // R10: power-down refuses programming
        pd = 1'b1;
        base = wr_cnt;
        xfer(5, 21'h13579, 3'd0);
        check("R10 no write in power-down", wr_cnt - base, 0);
        check("R10 err_n unchanged", err_n, 1);
        pd = 1'b0;
        base = wr_cnt;
        xfer(6, 21'h13579, 3'd6);
        check("R10 write after power-up", wr_cnt - base, 1);
        check("R10 select after power-up", last_sel, 6'b100000);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule